// File: doc/BRIEF.md
# Pipelined Converter Redundancy Corrector

This block sits behind a nine-stage pipelined analog-to-digital converter. The first eight stages each resolve 1.5 bits and report a redundant 2-bit code. The ninth stage is a plain flash quantizer with its own 2-bit code. The stages work in an interleaved fashion, so the codes that belong to one analog sample do not arrive together. Stage 1 reports first, and each later stage reports one clock after the stage before it.

The corrector captures every stage code together with its strobe. It holds each code in a delay line whose length depends on the stage, so that all nine codes of one sample meet in the same cycle. It then merges them by pure addition. Neighbouring codes overlap by one bit, so any carry moves toward the most significant bit. The registered result is a 10-bit word. After the pipeline fills, one word is produced every clock.

Top module: `pipe_adc_corrector`

## Requirements
- R1: Code values are plain unsigned binary (0, 1 or 2). Stage codes arrive packed on `stage_codes`, with stage k (k = 1..9) on bits [2k-1:2k-2]. A valid output word equals the sum of code(k)·2^(9−k) for k = 1..8, plus code(9)·1.
- R2: The output is never saturated or clipped. All nine codes at 2 give 1022, the largest value, and all codes at 0 give 0.
- R3: For one sample, stage k's code and strobe are presented k−1 cycles after stage 1's code. The corrector combines exactly these staggered codes into one word.
- R4: The output is delayed a fixed 10 clock cycles from the cycle in which stage 1's code is presented. After a reset, `corr_valid` stays low for at least the first 10 cycles.
- R5: Samples that start in consecutive cycles come out in consecutive cycles, one corrected word per clock, with no gaps.
- R6: `corr_valid` is high for a sample only if all nine stage strobes were high when their codes for that sample were presented. If any strobe is missing, that output cycle shows `corr_valid` low, and the neighbouring samples are not affected.
- R7: A synchronous active-high `rst` forces `corr_valid` and `corr_word` to 0 on the next edge. It also discards every sample that is already in flight.
- R8: Overlap carries go toward the MSB. A word whose lower stages are all at 2 must carry into the higher positions. For example, stage 1 at 1 and stages 2..9 at 2 give 766, and stage 1 at 0 with stages 2..9 at 2 gives 510.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stage_codes | input | 18 | Packed stage codes; stage k on bits [2k-1:2k-2] |
| stage_valid | input | 9 | Per-stage strobe; bit k-1 qualifies stage k's code |
| corr_word | output | 10 | Corrected, registered output word |
| corr_valid | output | 1 | High when corr_word holds a sample with all nine codes present |

## Verification
Directed vectors cover several cases:
- All zeros, all ones and all twos, which confirm the endpoints and the 1022 ceiling.
- A single stage active at the top or at the bottom, which shows that each weight sits at the right position.
- Alternating patterns, which would expose a swapped or misaligned stage.
- Vectors with every lower stage at 2, which can only come out right if carries reach the MSB side.

A long back-to-back run of random codes checks the 10-cycle delay and the one-word-per-clock rate against a weighted-sum model in the bench. A stream with single strobes withheld from chosen samples shows that only those samples lose `corr_valid`. A reset issued while samples are in flight must leave nothing behind.

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int NSTG = 9,
  parameter int CW   = 2,
  parameter int OW   = NSTG + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSTG*CW-1:0]   stage_codes,
  input  logic [NSTG-1:0]      stage_valid,
  output logic [OW-1:0]        corr_word,
  output logic                 corr_valid
);

  logic [CW-1:0] aligned_code [NSTG];
  logic [NSTG-1:0] aligned_vld;
  logic [OW-1:0] sum_c;

  // stage i waits NSTG-i registers (input capture included)
  for (genvar i = 0; i < NSTG; i++) begin : g_dly
    localparam int DEPTH = NSTG - i;
    logic [CW-1:0] cdl [DEPTH];
    logic [DEPTH-1:0] vdl;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < DEPTH; j++) cdl[j] <= '0;
        vdl <= '0;
      end else begin
        cdl[0] <= stage_codes[i*CW +: CW];
        vdl[0] <= stage_valid[i];
        for (int j = 1; j < DEPTH; j++) begin
          cdl[j] <= cdl[j-1];
          vdl[j] <= vdl[j-1];
        end
      end
    end

    assign aligned_code[i] = cdl[DEPTH-1];
    assign aligned_vld[i]  = vdl[DEPTH-1];
  end

  // overlap-add: each code sits one bit above its successor
  always_comb begin
    sum_c = OW'(aligned_code[NSTG-1]);
    for (int i = 0; i < NSTG - 1; i++)
      sum_c = sum_c + (OW'(aligned_code[i]) << (NSTG - 1 - i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr_word  <= '0;
      corr_valid <= 1'b0;
    end else begin
      corr_word  <= sum_c;
      corr_valid <= &aligned_vld;
    end
  end

endmodule

module adc_corr_checks #(
  parameter int NSTG = 9,
  parameter int OW   = NSTG + 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NSTG-1:0] stage_valid,
  input logic [OW-1:0]   corr_word,
  input logic            corr_valid
);

  logic [3:0] since_rst;
  logic [9:0] first_hist;
  logic [1:0] last_hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst  <= '0;
      first_hist <= '0;
      last_hist  <= '0;
    end else begin
      if (since_rst != 4'd15) since_rst <= since_rst + 4'd1;
      first_hist <= {first_hist[8:0], stage_valid[0]};
      last_hist  <= {last_hist[0], stage_valid[NSTG-1]};
    end
  end

  p_max_word_r2: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> (corr_word <= OW'(1022)));

  p_fill_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 4'd10) |-> !corr_valid);

  p_first_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> first_hist[9]);

  p_last_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    corr_valid |-> last_hist[1]);

  p_clear_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 4'd1) |-> (!corr_valid && corr_word == '0));

endmodule

bind pipe_adc_corrector adc_corr_checks #(.NSTG(NSTG), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .stage_valid(stage_valid),
  .corr_word(corr_word), .corr_valid(corr_valid));

// File: tb/pipe_adc_corrector_bench.sv
`timescale 1ns/1ps
module pipe_adc_corrector_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] stage_codes = '0;
  logic [8:0]  stage_valid = '0;
  logic [9:0]  corr_word;
  logic        corr_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_adc_corrector u_pipe_adc_corrector (
    .clk(clk), .rst(rst), .stage_codes(stage_codes), .stage_valid(stage_valid),
    .corr_word(corr_word), .corr_valid(corr_valid));

  // {stage1 .. stage9 codes, expected word}
  localparam logic [27:0] VEC [14] = '{
    {2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0, 10'd0},
    {2'd1,2'd1,2'd1,2'd1,2'd1,2'd1,2'd1,2'd1,2'd1, 10'd511},
    {2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2, 10'd1022},
    {2'd2,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0, 10'd512},
    {2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd2, 10'd2},
    {2'd1,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0, 10'd256},
    {2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd0,2'd2,2'd2, 10'd6},
    {2'd0,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2, 10'd510},
    {2'd1,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2, 10'd766},
    {2'd2,2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0,2'd2, 10'd682},
    {2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0, 10'd340},
    {2'd1,2'd0,2'd1,2'd0,2'd1,2'd0,2'd1,2'd0,2'd1, 10'd341},
    {2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd2,2'd0, 10'd1020},
    {2'd0,2'd1,2'd2,2'd0,2'd1,2'd2,2'd0,2'd1,2'd2, 10'd292}
  };

  logic [17:0] sc [64];
  logic [8:0]  sm [64];
  logic [9:0]  se [64];

  function automatic logic [9:0] ref_sum(input logic [17:0] pc);
    int acc = pc[17:16];
    for (int k = 0; k < 8; k++) acc += int'(pc[2*k +: 2]) << (8 - k);
    return 10'(acc);
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    stage_codes = '0;
    stage_valid = '0;
  endtask

  // stage i carries sample c-i in cycle c; output of sample s seen in cycle s+10
  task automatic run_stream(input int n, input string req);
    for (int c = 0; c < n + 11; c++) begin
      @(negedge clk);
      if (c - 10 >= 0 && c - 10 < n) begin
        check({req, " R4 R5 R6 valid"}, 10'(corr_valid), 10'(&sm[c-10]));
        if (&sm[c-10]) check({req, " R1 R3 word"}, corr_word, se[c-10]);
      end else begin
        check({req, " R4 idle valid"}, 10'(corr_valid), 10'd0);
      end
      for (int i = 0; i < 9; i++) begin
        if (c - i >= 0 && c - i < n) begin
          stage_codes[2*i +: 2] = sc[c-i][2*i +: 2];
          stage_valid[i]        = sm[c-i][i];
        end else begin
          stage_codes[2*i +: 2] = 2'd0;
          stage_valid[i]        = 1'b0;
        end
      end
    end
    drive_idle();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset valid", 10'(corr_valid), 10'd0);
    check("R7 reset word", corr_word, 10'd0);
    rst = 1'b0;

    // table of directed vectors (R1 R2 R8 inside)
    for (int v = 0; v < 14; v++) begin
      for (int k = 0; k < 9; k++) sc[v][2*k +: 2] = VEC[v][27 - 2*k -: 2];
      sm[v] = '1;
      se[v] = VEC[v][9:0];
    end
    run_stream(14, "R1 R2 R8 table");

    // random back-to-back stream
    for (int v = 0; v < 60; v++) begin
      for (int k = 0; k < 9; k++) sc[v][2*k +: 2] = 2'($urandom_range(0, 2));
      sm[v] = '1;
      se[v] = ref_sum(sc[v]);
    end
    run_stream(60, "R5 random");

    // withheld strobes: R6
    for (int v = 0; v < 10; v++) begin
      for (int k = 0; k < 9; k++) sc[v][2*k +: 2] = 2'($urandom_range(0, 2));
      sm[v] = '1;
      se[v] = ref_sum(sc[v]);
    end
    sm[2][4] = 1'b0;
    sm[4][0] = 1'b0;
    sm[6][8] = 1'b0;
    run_stream(10, "R6 strobes");

    // reset in flight: R7
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      for (int i = 0; i < 9; i++) begin
        stage_codes[2*i +: 2] = 2'd2;
        stage_valid[i] = 1'b1;
      end
    end
    @(negedge clk);
    drive_idle();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 flush valid", 10'(corr_valid), 10'd0);
    check("R7 flush word", corr_word, 10'd0);
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      check("R7 flushed valid", 10'(corr_valid), 10'd0);
      check("R7 flushed word", corr_word, 10'd0);
    end

    // latency after reset: single sample, all twos, R4
    for (int k = 0; k < 9; k++) sc[0][2*k +: 2] = 2'd2;
    sm[0] = '1;
    se[0] = 10'd1022;
    run_stream(1, "R4 R2 single");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule